// File: doc/BRIEF.md
# DRAM Strobe Sequencer with Periodic Refresh

This block sits between a simple word-wide request port and an asynchronous dynamic RAM that takes its address in two halves over one shared bus. For every accepted request it places the row half on the bus and pulls the row strobe low. It then swaps to the column half and pulls the column strobe low. The write strobe is set before that second strobe falls. The data bus is bidirectional: the block drives it only while a write is in progress. At the end of a read it samples the word that the memory puts on the bus.

Stored charge leaks away, so a free-running interval counter raises a refresh demand. The sequencer serves that demand with a column-before-row strobe cycle, in which the memory picks the row itself. Refresh outranks user traffic. A demand raised during an access is served as soon as that access has precharged, and no new request is accepted while a demand is outstanding. Every timing window is a cycle-count parameter. All strobes return high between cycles.

Top module: `dram_rascas_ctrl`

## Requirements
- R1: While reset is held, and in the first idle cycle after it, the row, column and write strobes are high, `req_ready` is high and `rd_valid` is low.
- R2: On an access, the accepted row (zero-extended) is on `dram_addr` when `dram_ras_n` falls with `dram_cas_n` high. The accepted column is on `dram_addr` when `dram_cas_n` falls with `dram_ras_n` low.
- R3: `dram_we_n` holds its final level (low means write, high means read) from at least one cycle before `dram_cas_n` falls until `dram_cas_n` rises again.
- R4: On an access, `dram_ras_n` has been low for at least `T_RCD` cycles when `dram_cas_n` falls, and `dram_cas_n` stays low for `T_CAS` cycles.
- R5: Before every falling edge of `dram_ras_n`, `dram_ras_n` has been high for at least `T_RP` cycles.
- R6: A refresh pulls `dram_cas_n` low while `dram_ras_n` is high, keeps it low for `T_CSR` cycles, then pulls `dram_ras_n` low for `T_REF_RAS` cycles. During the whole refresh `dram_we_n` stays high and the block does not drive `dram_dq`.
- R7: A refresh demand is raised every `REFRESH_INTERVAL` cycles. It is served before any new request, and at most one access after it is raised.
- R8: `req_ready` is high only when the sequencer is idle with no refresh outstanding, and then all strobes are high. A request is taken in the cycle where `req_valid` and `req_ready` are both high.
- R9: Every accepted read yields exactly one single-cycle `rd_valid` pulse carrying the stored word. Read results come back in the order the reads were accepted.
- R10: The block drives `dram_dq` only during a write, and only while `dram_ras_n` is low. It drives the accepted write word, and that word is what gets stored.
- R11: Contents survive arbitrarily long idle stretches and long runs of back-to-back accesses. No row goes unrefreshed past the memory's retention limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row half of the word address |
| req_col | input | COL_W | Column half of the word address |
| req_wdata | input | DATA_W | Word to write |
| req_ready | output | 1 | Request can be taken this cycle |
| rd_data | output | DATA_W | Word returned by a read |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` valid |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_dq | inout | DATA_W | Bidirectional data bus |

## Verification
The awkward case is a refresh demand that ripens while an access is in flight or while a request is already waiting. From the ports this is a timing coincidence that cannot be scheduled directly. The stimulus therefore drives long unbroken streams of requests over every address, so the fixed interval lands on every phase of the access sequence again and again. The memory model on the bench lets any row decay that misses its retention limit. Read-back after such streams, and after a long idle gap, shows whether refresh kept its place in line. The model also counts refresh cycles per window and records the shortest precharge and row-to-column gaps it saw.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ROW,
        PH_RAS,
        PH_COL,
        PH_CAS,
        PH_CSR,
        PH_RFSH,
        PH_PRE
    } phase_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic col_sel;
        logic drive;
    } strobe_t;

    // Strobe levels for a phase; wr tells whether the held access writes.
    function automatic strobe_t phase_strobes(phase_e ph, logic wr);
        strobe_t s;
        s = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, col_sel: 1'b0, drive: 1'b0};
        case (ph)
            PH_RAS: s.ras_n = 1'b0;
            PH_COL: begin
                s.ras_n   = 1'b0;
                s.col_sel = 1'b1;
                s.we_n    = ~wr;
                s.drive   = wr;
            end
            PH_CAS: begin
                s.ras_n   = 1'b0;
                s.cas_n   = 1'b0;
                s.col_sel = 1'b1;
                s.we_n    = ~wr;
                s.drive   = wr;
            end
            PH_CSR:  s.cas_n = 1'b0;
            PH_RFSH: begin
                s.cas_n = 1'b0;
                s.ras_n = 1'b0;
            end
            default: ;
        endcase
        return s;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int INTERVAL = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pending
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            cnt     <= wrap ? '0 : cnt + CW'(1);
            pending <= (pending & ~ack) | wrap;
        end
    end
endmodule

// File: rtl/dram_phase_timer.sv
module dram_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (load) begin
            left <= load_val;
        end else if (left != '0) begin
            left <= left - TW'(1);
        end
    end

    assign done = (left == '0);
endmodule

// File: rtl/dram_rascas_ctrl.sv
module dram_rascas_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W            = 4,
    parameter int COL_W            = 4,
    parameter int DATA_W           = 16,
    parameter int T_RCD            = 2,
    parameter int T_CAS            = 2,
    parameter int T_RP             = 2,
    parameter int T_CSR            = 1,
    parameter int T_REF_RAS        = 3,
    parameter int REFRESH_INTERVAL = 64
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  req_valid,
    input  logic                                  req_we,
    input  logic [ROW_W-1:0]                      req_row,
    input  logic [COL_W-1:0]                      req_col,
    input  logic [DATA_W-1:0]                     req_wdata,
    output logic                                  req_ready,
    output logic [DATA_W-1:0]                     rd_data,
    output logic                                  rd_valid,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic                                  dram_ras_n,
    output logic                                  dram_cas_n,
    output logic                                  dram_we_n,
    inout  wire  [DATA_W-1:0]                     dram_dq
);
    localparam int ADDR_W = max2(ROW_W, COL_W);
    localparam int MAX_T  = max2(max2(max2(T_RCD, T_CAS), max2(T_RP, T_CSR)), T_REF_RAS);
    localparam int TW     = (MAX_T > 1) ? $clog2(MAX_T + 1) : 1;

    typedef struct packed {
        logic              we;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
    } acc_req_t;

    phase_e   phase, phase_nx;
    acc_req_t held;
    strobe_t  stb;
    logic     ref_pending, ref_ack;
    logic     tmr_done, tmr_load;
    logic [TW-1:0] tmr_val;
    logic     take;
    logic     dq_oe;
    int       nx_len;

    dram_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_ref (
        .clk     (clk),
        .rst     (rst),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    dram_phase_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign req_ready = (phase == PH_IDLE) && !ref_pending;
    assign take      = req_valid && req_ready;
    assign ref_ack   = (phase == PH_IDLE) && ref_pending;

    // Sequencing: each timed phase lasts its parameter count of cycles.
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE: begin
                if (ref_pending)    phase_nx = PH_CSR;
                else if (req_valid) phase_nx = PH_ROW;
            end
            PH_ROW:  phase_nx = PH_RAS;
            PH_RAS:  if (tmr_done) phase_nx = PH_COL;
            PH_COL:  phase_nx = PH_CAS;
            PH_CAS:  if (tmr_done) phase_nx = PH_PRE;
            PH_CSR:  if (tmr_done) phase_nx = PH_RFSH;
            PH_RFSH: if (tmr_done) phase_nx = PH_PRE;
            PH_PRE:  if (tmr_done) phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_comb begin
        case (phase_nx)
            PH_RAS:  nx_len = T_RCD;
            PH_CAS:  nx_len = T_CAS;
            PH_CSR:  nx_len = T_CSR;
            PH_RFSH: nx_len = T_REF_RAS;
            PH_PRE:  nx_len = T_RP;
            default: nx_len = 1;
        endcase
    end

    assign tmr_load = (phase_nx != phase);
    assign tmr_val  = TW'(nx_len - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            held  <= '0;
        end else begin
            phase <= phase_nx;
            if (take) begin
                held.we    <= req_we;
                held.row   <= req_row;
                held.col   <= req_col;
                held.wdata <= req_wdata;
            end
        end
    end

    // Read word is sampled on the last cycle of the column strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (phase == PH_CAS && tmr_done && !held.we) begin
                rd_valid <= 1'b1;
                rd_data  <= dram_dq;
            end
        end
    end

    assign stb        = phase_strobes(phase, held.we);
    assign dram_ras_n = stb.ras_n;
    assign dram_cas_n = stb.cas_n;
    assign dram_we_n  = stb.we_n;
    assign dram_addr  = stb.col_sel ? ADDR_W'(held.col) : ADDR_W'(held.row);
    assign dq_oe      = stb.drive;
    assign dram_dq    = dq_oe ? held.wdata : {DATA_W{1'bz}};

endmodule

// File: rtl/dram_rascas_ctrl_chk.sv
module dram_rascas_ctrl_chk #(
    parameter int ROW_W            = 4,
    parameter int COL_W            = 4,
    parameter int ADDR_W           = 4,
    parameter int T_RCD            = 2,
    parameter int T_CAS            = 2,
    parameter int T_RP             = 2,
    parameter int T_CSR            = 1,
    parameter int T_REF_RAS        = 3,
    parameter int REFRESH_INTERVAL = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_we,
    input logic [ROW_W-1:0]  req_row,
    input logic [COL_W-1:0]  req_col,
    input logic [ADDR_W-1:0] dram_addr,
    input logic              dram_ras_n,
    input logic              dram_cas_n,
    input logic              dram_we_n,
    input logic              dq_oe,
    input logic              rd_valid
);
    localparam int GAP_MAX = REFRESH_INTERVAL + T_RCD + T_CAS + 2 * T_RP
                           + T_CSR + T_REF_RAS + 8;

    logic [ROW_W-1:0] c_row;
    logic [COL_W-1:0] c_col;
    logic             c_we;
    logic [31:0]      ras_hi, ras_lo, cas_lo, since_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_row     <= '0;
            c_col     <= '0;
            c_we      <= 1'b0;
            ras_hi    <= 32'hFFFF_0000;
            ras_lo    <= '0;
            cas_lo    <= '0;
            since_ref <= '0;
        end else begin
            if (req_valid && req_ready) begin
                c_row <= req_row;
                c_col <= req_col;
                c_we  <= req_we;
            end
            ras_hi    <= dram_ras_n ? ras_hi + 32'd1 : 32'd0;
            ras_lo    <= dram_ras_n ? 32'd0 : ras_lo + 32'd1;
            cas_lo    <= dram_cas_n ? 32'd0 : cas_lo + 32'd1;
            since_ref <= (!dram_cas_n && dram_ras_n && cas_lo == 32'd0) ? 32'd0
                                                                       : since_ref + 32'd1;
        end
    end

    p_idle_strobes_r8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (dram_ras_n && dram_cas_n && dram_we_n));

    p_row_addr_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_ras_n) && dram_cas_n) |-> (dram_addr == ADDR_W'(c_row)));

    p_col_addr_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_cas_n) && !dram_ras_n) |-> (dram_addr == ADDR_W'(c_col)));

    p_we_setup_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_cas_n) |-> $stable(dram_we_n));

    p_we_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_we_n));

    p_we_level_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_cas_n) && !dram_ras_n) |-> (dram_we_n == !c_we));

    p_rcd_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_cas_n) && !dram_ras_n) |-> (ras_lo >= 32'(T_RCD)));

    p_precharge_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> (ras_hi >= 32'(T_RP)));

    p_refresh_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!dram_cas_n && dram_ras_n) |-> (dram_we_n && !dq_oe));

    p_refresh_gap_r7: assert property (@(posedge clk) disable iff (rst)
        since_ref <= 32'(GAP_MAX));

    p_read_source_r9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!dram_cas_n && !dram_ras_n && dram_we_n));

    p_read_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    p_drive_window_r10: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!dram_we_n && !dram_ras_n));

endmodule

bind dram_rascas_ctrl dram_rascas_ctrl_chk #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_CSR(T_CSR),
    .T_REF_RAS(T_REF_RAS), .REFRESH_INTERVAL(REFRESH_INTERVAL)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_row(req_row), .req_col(req_col),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dq_oe(dq_oe), .rd_valid(rd_valid)
);

// File: tb/test_dram_rascas_ctrl.sv
module test_dram_rascas_ctrl;
    localparam int ROW_W = 4;
    localparam int COL_W = 4;
    localparam int DW    = 16;
    localparam int T_RCD = 2;
    localparam int T_CAS = 2;
    localparam int T_RP  = 2;
    localparam int T_CSR = 1;
    localparam int T_REF_RAS = 3;
    localparam int INTV  = 40;
    localparam int ROWS  = 1 << ROW_W;
    localparam int WORDS = ROWS << COL_W;
    localparam int LIMIT = 700;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic [3:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n;
    wire  [DW-1:0] dq_bus;

    always #5 clk = ~clk;

    dram_rascas_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
        .T_RP(T_RP), .T_CSR(T_CSR), .T_REF_RAS(T_REF_RAS), .REFRESH_INTERVAL(INTV)
    ) i_dram_rascas_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_dq(dq_bus)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- memory model with decay ----------------
    logic [DW-1:0] mem [WORDS];
    int  age [ROWS];
    bit  dead [ROWS];
    int  refreshes = 0, viol = 0, dead_rows = 0;
    int  min_rp = 1000, min_rcd = 1000;
    int  ras_hi = 1000, ras_lo = 0, ref_ptr = 0;
    bit  open_row = 0, m_drive = 0;
    int  o_row = 0;
    logic [DW-1:0] m_q = '0;
    logic p_ras = 1, p_cas = 1, p_we = 1;

    assign dq_bus = m_drive ? m_q : {DW{1'bz}};

    always @(negedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) begin age[r] = 0; dead[r] = 0; end
            p_ras = 1; p_cas = 1; p_we = 1; m_drive = 0; open_row = 0;
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                age[r]++;
                if (age[r] > LIMIT && !dead[r]) begin dead[r] = 1; dead_rows++; end
            end
            if (p_ras && !dram_ras_n) begin
                if (ras_hi < min_rp) min_rp = ras_hi;
                ras_lo = 0;
                if (!dram_cas_n) begin
                    refreshes++;
                    if (!dram_we_n) viol++;
                    age[ref_ptr] = 0;
                    ref_ptr = (ref_ptr + 1) % ROWS;
                end else begin
                    open_row = 1;
                    o_row = int'(dram_addr);
                    age[o_row] = 0;
                end
            end
            if (p_cas && !dram_cas_n && !dram_ras_n && open_row) begin
                int idx;
                if (ras_lo < min_rcd) min_rcd = ras_lo;
                if (dram_we_n != p_we) viol++;
                idx = (o_row << COL_W) + int'(dram_addr);
                if (!dram_we_n) mem[idx] = dq_bus;
                else begin
                    m_q = dead[o_row] ? ~mem[idx] : mem[idx];
                    m_drive = 1;
                end
            end
            if (!p_cas && !dram_cas_n && dram_we_n != p_we) viol++;
            if (dram_cas_n) m_drive = 0;
            if (dram_ras_n) begin open_row = 0; ras_hi++; end
            else begin ras_hi = 0; ras_lo++; end
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
        end
    end

    // ---------------- scoreboard ----------------
    logic [DW-1:0] shadow [WORDS];
    logic [DW-1:0] exp_q [$];

    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected read result", 32'(rd_data), 32'h0);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R9/R10 read data", 32'(rd_data), 32'(e));
            end
        end
    end

    task automatic issue(input logic we, input int idx, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_wdata = d;
        req_row = ROW_W'(idx >> COL_W); req_col = COL_W'(idx);
        while (!req_ready) @(negedge clk);
        if (we) shadow[idx] = d;
        else exp_q.push_back(shadow[idx]);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 ready drops after accept", 32'(req_ready), 32'h0);
    endtask

    task automatic drain;
        int n = 0;
        while (exp_q.size() != 0 && n < 200) begin @(negedge clk); n++; end
        chk(exp_q.size() == 0, "R9 all reads returned", 32'(exp_q.size()), 32'h0);
    endtask

    function automatic logic [DW-1:0] pat(input int i, input int k);
        return DW'(i * 40503 + k * 12345) ^ 16'h5A5A;
    endfunction

    initial begin
        int r0, cyc0, got, expn;
        repeat (3) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes high in reset",
            {29'b0, dram_ras_n, dram_cas_n, dram_we_n}, 32'h7);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
        chk(rd_valid == 1'b0, "R1 no read result after reset", 32'(rd_valid), 32'h0);
        chk(dram_ras_n && dram_cas_n, "R1 strobes high after reset",
            {30'b0, dram_ras_n, dram_cas_n}, 32'h3);

        // corner patterns, then every word written back-to-back (R2, R10)
        issue(1'b1, 0, 16'h0000);
        issue(1'b1, WORDS - 1, 16'hFFFF);
        issue(1'b0, 0, 16'h0);
        issue(1'b0, WORDS - 1, 16'h0);
        drain();
        cyc0 = 0; r0 = refreshes;
        fork
            begin
                for (int i = 0; i < WORDS; i++) issue(1'b1, i, pat(i, 0));
            end
            begin
                while (req_valid || cyc0 == 0 || !req_ready) begin
                    @(negedge clk); cyc0++;
                    if (cyc0 > 100000) break;
                end
            end
        join_any
        wait fork;
        got = refreshes - r0; expn = cyc0 / INTV;
        chk(got >= expn - 2 && got <= expn + 2, "R7 refresh rate under load",
            32'(got), 32'(expn));
        for (int i = 0; i < WORDS; i++) issue(1'b0, i, 16'h0);
        drain();

        // long idle stretch: refresh alone must keep the rows (R11)
        r0 = refreshes;
        repeat (3000) @(negedge clk);
        got = refreshes - r0;
        chk(got >= 74 && got <= 76, "R7 refresh count while idle", 32'(got), 32'd75);
        for (int i = 0; i < WORDS; i++) issue(1'b0, i, 16'h0);
        drain();

        // interleaved writes and reads with a second pattern (R3, R9)
        for (int i = 0; i < WORDS; i += 3) begin
            issue(1'b1, i, pat(i, 7));
            issue(1'b0, (i * 5) % WORDS, 16'h0);
        end
        drain();
        repeat (2000) @(negedge clk);
        for (int i = 0; i < WORDS; i += 7) issue(1'b0, i, 16'h0);
        drain();

        chk(dead_rows == 0, "R11 no row decayed", 32'(dead_rows), 32'h0);
        chk(viol == 0, "R3/R6 strobe protocol faults", 32'(viol), 32'h0);
        chk(min_rp >= T_RP, "R5 shortest precharge", 32'(min_rp), 32'(T_RP));
        chk(min_rcd >= T_RCD, "R4 shortest row-to-column gap", 32'(min_rcd), 32'(T_RCD));
        chk(refreshes > 0, "R6 refresh cycles seen", 32'(refreshes), 32'h1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule